// File: doc/BRIEF.md
# Wireless MAC Header Flag Classifier

This block takes the leading fields of a received 802.11 MAC frame and turns them into one 32-bit attention status word per frame. The word is accompanied by the extracted sequence number, the traffic identifier and four copied frame-control bits. The header fields arrive together on parallel inputs and are qualified by a valid/ready handshake:

- frame control
- duration
- three addresses
- sequence control
- QoS control

Side inputs say whether this status belongs to the first MSDU of its MPDU. They also carry the first-MPDU, last-MPDU and FCS-error indications that come from elsewhere in the receive path. Four programmable BSSID values and the station's own address are plain configuration inputs.

The result leaves through a one-entry output register with its own valid/ready pair. An input beat is accepted when `in_valid` and `in_ready` are both high, and `in_ready` is high whenever the output register is empty or is being drained in the same cycle. This gives full throughput with no bubble. Under back-pressure the held result does not change, and new headers wait at the input. Peer lookup, encryption policy and FCS computation lie outside this block.

Top module: `wlan_hdr_classifier`

## Requirements
- R1: A header accepted on a rising edge (in_valid and in_ready high) appears on the outputs with out_valid high after that same edge. in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, every output holds its value.
- R2: Status bit 0 copies first_mpdu, bit 1 copies last_mpdu and bit 30 copies fcs_err, whatever the first-MSDU qualifier is.
- R3: When first_msdu is low, all header-derived status bits are zero, and so are out_seq_num, out_tid, out_retry, out_protected, out_to_ds and out_from_ds.
- R4: The frame control layout is: type in bits [3:2], subtype in bits [7:4], to-DS 8, from-DS 9, more-fragments 10, retry 11, power-management 12, more-data 13, protected 14, order 15. Type 2'b00 sets status bit 8 (management), type 2'b01 sets status bit 9 (control), and type 2'b10 is data.
- R5: Status bit 5 copies power-management, bit 10 copies more-data and bit 14 copies order. The out_retry, out_protected, out_to_ds and out_from_ds outputs copy the matching frame-control bits.
- R6: Status bit 13 (fragment) is set when more-fragments is set or when the fragment number (sequence control bits [3:0]) is non-zero.
- R7: Status bit 7 is set for data frames with subtype 4'b0100 (null data) and for data frames with subtype 4'b1100 (QoS null).
- R8: The QoS field is present only for data frames whose subtype bit 3 is set. When it is present, status bit 11 copies QoS bit 4 and out_tid is QoS bits [3:0]. When it is absent, both are zero.
- R9: Status bit 2 is set when address 1 bit 0 is set and the frame's BSSID equals one of the four BSSID inputs. The BSSID is taken from address 3 when to-DS and from-DS are both clear, from address 1 when only to-DS is set, and from address 2 when only from-DS is set. There is no match when both are set.
- R10: Status bit 25 is set when address 1 equals the station address.
- R11: out_seq_num is sequence control bits [15:4].
- R12: All status bits other than 0, 1, 2, 5, 7, 8, 9, 10, 11, 13, 14, 25 and 30 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Header beat valid |
| in_ready | output | 1 | Header beat can be accepted |
| hdr_fc | input | 16 | Frame control |
| hdr_duration | input | 16 | Duration/ID (carried, not decoded) |
| hdr_addr1 | input | 48 | Address 1 (receiver) |
| hdr_addr2 | input | 48 | Address 2 |
| hdr_addr3 | input | 48 | Address 3 |
| hdr_seq_ctl | input | 16 | Sequence control |
| hdr_qos_ctl | input | 16 | QoS control (meaningful only when present) |
| first_msdu | input | 1 | Status belongs to the first MSDU of the MPDU |
| first_mpdu | input | 1 | First MPDU indication, passed to status |
| last_mpdu | input | 1 | Last MPDU indication, passed to status |
| fcs_err | input | 1 | FCS failure indication, passed to status |
| bssid_tbl | input | 192 | Four BSSID values, entry k at bits [48k+47:48k] |
| sta_addr | input | 48 | Own station address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream takes the result |
| out_status | output | 32 | Attention status word |
| out_seq_num | output | 12 | Sequence number |
| out_tid | output | 4 | Traffic identifier |
| out_retry | output | 1 | Retry bit |
| out_protected | output | 1 | Protected bit |
| out_to_ds | output | 1 | To-DS bit |
| out_from_ds | output | 1 | From-DS bit |

## Verification
The only state is the output register, so a wrong state shows up at the ports in the first cycle after an accepted header or a stalled handshake. A wrong state can be a result that was loaded wrongly, lost, or overwritten while stalled. It appears as a status word, TID or sequence number that does not match the header that was offered, or as a result that changes while out_ready is low. Decode faults show up the same cycle, as one wrong flag bit. The stimulus therefore covers every frame type, both QoS presence cases, all four DS-bit combinations for BSSID selection, and the qualifier-low case. A stall that overlaps a waiting header checks both the hold behaviour and the accept-on-drain behaviour.

// File: rtl/wlan_hdr_pkg.sv
package wlan_hdr_pkg;
  localparam int ADDR_W = 48;
  localparam int STAT_W = 32;
  localparam int SEQ_W  = 12;
  localparam int TID_W  = 4;

  // status word bit positions (consumed downstream, so fixed)
  localparam int ST_FIRST_MPDU = 0;
  localparam int ST_LAST_MPDU  = 1;
  localparam int ST_GROUP_BSS  = 2;
  localparam int ST_PWR_SAVE   = 5;
  localparam int ST_NULL       = 7;
  localparam int ST_MGMT       = 8;
  localparam int ST_CTRL       = 9;
  localparam int ST_MORE_DATA  = 10;
  localparam int ST_EOSP       = 11;
  localparam int ST_FRAG       = 13;
  localparam int ST_ORDER      = 14;
  localparam int ST_DIRECTED   = 25;
  localparam int ST_FCS_ERR    = 30;

  localparam logic [STAT_W-1:0] HDR_MASK =
    (32'd1 << ST_GROUP_BSS) | (32'd1 << ST_PWR_SAVE) | (32'd1 << ST_NULL) |
    (32'd1 << ST_MGMT) | (32'd1 << ST_CTRL) | (32'd1 << ST_MORE_DATA) |
    (32'd1 << ST_EOSP) | (32'd1 << ST_FRAG) | (32'd1 << ST_ORDER) |
    (32'd1 << ST_DIRECTED);
  localparam logic [STAT_W-1:0] PASS_MASK =
    (32'd1 << ST_FIRST_MPDU) | (32'd1 << ST_LAST_MPDU) | (32'd1 << ST_FCS_ERR);
  localparam logic [STAT_W-1:0] USED_MASK = HDR_MASK | PASS_MASK;

  typedef enum logic [1:0] {
    FT_MGMT = 2'b00,
    FT_CTRL = 2'b01,
    FT_DATA = 2'b10,
    FT_EXT  = 2'b11
  } frame_kind_e;

  typedef struct packed {
    logic              mgmt;
    logic              ctrl;
    logic              null_frm;
    logic              pwr_save;
    logic              more_data;
    logic              order;
    logic              retry;
    logic              prot;
    logic              to_ds;
    logic              from_ds;
    logic              frag;
    logic              eosp;
    logic [TID_W-1:0]  tid;
    logic [SEQ_W-1:0]  seq;
  } fc_info_t;
endpackage

// File: rtl/whc_fc_decode.sv
module whc_fc_decode
  import wlan_hdr_pkg::*;
(
  input  logic [15:0] fc,
  input  logic [15:0] seq_ctl,
  input  logic [15:0] qos_ctl,
  output fc_info_t    info
);
  frame_kind_e kind;
  logic [3:0]  subtype;
  logic        is_data;
  logic        has_qos;

  always_comb begin
    kind    = frame_kind_e'(fc[3:2]);
    subtype = fc[7:4];
    is_data = (kind == FT_DATA);
    has_qos = is_data && subtype[3];

    info           = '0;
    info.mgmt      = (kind == FT_MGMT);
    info.ctrl      = (kind == FT_CTRL);
    info.null_frm  = is_data && (subtype[2:0] == 3'b100);
    info.to_ds     = fc[8];
    info.from_ds   = fc[9];
    info.retry     = fc[11];
    info.pwr_save  = fc[12];
    info.more_data = fc[13];
    info.prot      = fc[14];
    info.order     = fc[15];
    info.frag      = fc[10] || (seq_ctl[3:0] != 4'd0);
    info.eosp      = has_qos && qos_ctl[4];
    info.tid       = has_qos ? qos_ctl[TID_W-1:0] : '0;
    info.seq       = seq_ctl[15:4];
  end
endmodule

// File: rtl/whc_addr_match.sv
module whc_addr_match #(
  parameter int NUM_BSSID = 4,
  parameter int AW        = 48
) (
  input  logic [AW-1:0]           addr1,
  input  logic [AW-1:0]           addr2,
  input  logic [AW-1:0]           addr3,
  input  logic                    to_ds,
  input  logic                    from_ds,
  input  logic [NUM_BSSID*AW-1:0] bssid_tbl,
  input  logic [AW-1:0]           sta_addr,
  output logic                    group_bss,
  output logic                    directed
);
  logic [AW-1:0]        bss_pick;
  logic                 bss_usable;
  logic [NUM_BSSID-1:0] hit;

  always_comb begin
    bss_usable = 1'b1;
    unique case ({from_ds, to_ds})
      2'b00:   bss_pick = addr3;
      2'b01:   bss_pick = addr1;
      2'b10:   bss_pick = addr2;
      default: begin
        bss_pick   = '0;
        bss_usable = 1'b0;
      end
    endcase
  end

  for (genvar k = 0; k < NUM_BSSID; k++) begin : g_bss_cmp
    assign hit[k] = bss_usable && (bss_pick == bssid_tbl[k*AW +: AW]);
  end

  assign group_bss = addr1[0] && (|hit);
  assign directed  = (addr1 == sta_addr);
endmodule

// File: rtl/wlan_hdr_classifier.sv
module wlan_hdr_classifier
  import wlan_hdr_pkg::*;
#(
  parameter int NUM_BSSID = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [15:0]                 hdr_fc,
  input  logic [15:0]                 hdr_duration,
  input  logic [ADDR_W-1:0]           hdr_addr1,
  input  logic [ADDR_W-1:0]           hdr_addr2,
  input  logic [ADDR_W-1:0]           hdr_addr3,
  input  logic [15:0]                 hdr_seq_ctl,
  input  logic [15:0]                 hdr_qos_ctl,
  input  logic                        first_msdu,
  input  logic                        first_mpdu,
  input  logic                        last_mpdu,
  input  logic                        fcs_err,
  input  logic [NUM_BSSID*ADDR_W-1:0] bssid_tbl,
  input  logic [ADDR_W-1:0]           sta_addr,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [STAT_W-1:0]           out_status,
  output logic [SEQ_W-1:0]            out_seq_num,
  output logic [TID_W-1:0]            out_tid,
  output logic                        out_retry,
  output logic                        out_protected,
  output logic                        out_to_ds,
  output logic                        out_from_ds
);
  fc_info_t          info;
  logic              group_bss;
  logic              directed;
  logic              accept;
  logic [STAT_W-1:0] stat_nxt;
  logic [STAT_W-1:0] hdr_bits;
  logic              unused_hdr;

  // protocol version and duration are carried but not classified
  assign unused_hdr = ^{hdr_fc[1:0], hdr_duration, hdr_qos_ctl[15:5]};

  whc_fc_decode u_fc (
    .fc      (hdr_fc),
    .seq_ctl (hdr_seq_ctl),
    .qos_ctl (hdr_qos_ctl),
    .info    (info)
  );

  whc_addr_match #(.NUM_BSSID(NUM_BSSID), .AW(ADDR_W)) u_addr (
    .addr1     (hdr_addr1),
    .addr2     (hdr_addr2),
    .addr3     (hdr_addr3),
    .to_ds     (info.to_ds),
    .from_ds   (info.from_ds),
    .bssid_tbl (bssid_tbl),
    .sta_addr  (sta_addr),
    .group_bss (group_bss),
    .directed  (directed)
  );

  always_comb begin
    hdr_bits               = '0;
    hdr_bits[ST_GROUP_BSS] = group_bss;
    hdr_bits[ST_PWR_SAVE]  = info.pwr_save;
    hdr_bits[ST_NULL]      = info.null_frm;
    hdr_bits[ST_MGMT]      = info.mgmt;
    hdr_bits[ST_CTRL]      = info.ctrl;
    hdr_bits[ST_MORE_DATA] = info.more_data;
    hdr_bits[ST_EOSP]      = info.eosp;
    hdr_bits[ST_FRAG]      = info.frag;
    hdr_bits[ST_ORDER]     = info.order;
    hdr_bits[ST_DIRECTED]  = directed;

    stat_nxt                = first_msdu ? hdr_bits : '0;
    stat_nxt[ST_FIRST_MPDU] = first_mpdu;
    stat_nxt[ST_LAST_MPDU]  = last_mpdu;
    stat_nxt[ST_FCS_ERR]    = fcs_err;
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_status    <= '0;
      out_seq_num   <= '0;
      out_tid       <= '0;
      out_retry     <= 1'b0;
      out_protected <= 1'b0;
      out_to_ds     <= 1'b0;
      out_from_ds   <= 1'b0;
    end else begin
      if (accept) begin
        out_valid     <= 1'b1;
        out_status    <= stat_nxt;
        out_seq_num   <= first_msdu ? info.seq : '0;
        out_tid       <= first_msdu ? info.tid : '0;
        out_retry     <= first_msdu && info.retry;
        out_protected <= first_msdu && info.prot;
        out_to_ds     <= first_msdu && info.to_ds;
        out_from_ds   <= first_msdu && info.from_ds;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R1: accepted beat shows up after the edge
  a_r1_accept_lands: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R1: stalled result holds
  a_r1_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_status) &&
      $stable(out_tid) && $stable(out_seq_num)));

  // R2: pass-through bits follow their inputs
  a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_status[ST_FIRST_MPDU] == $past(first_mpdu) &&
      out_status[ST_LAST_MPDU] == $past(last_mpdu) &&
      out_status[ST_FCS_ERR] == $past(fcs_err)));

  // R3: qualifier low clears header-derived results
  a_r3_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !first_msdu) |=> ((out_status & HDR_MASK) == '0 &&
      out_tid == '0 && out_seq_num == '0 && !out_to_ds && !out_from_ds));

  // R4: management and control never together
  a_r4_kind_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_status[ST_CTRL:ST_MGMT]));

  // R7/R8: null and EOSP only on data frames
  a_r8_qos_data_only: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_status[ST_MGMT] || out_status[ST_CTRL])) |->
      (!out_status[ST_EOSP] && !out_status[ST_NULL] && out_tid == '0));

  // R12: unused positions stay clear
  a_r12_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_status & ~USED_MASK) == '0));
endmodule

// File: tb/wlan_hdr_classifier_test.sv
module wlan_hdr_classifier_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic         in_valid = 1'b0, in_ready;
  logic [15:0]  fc = '0, dur = '0, seqc = '0, qos = '0;
  logic [47:0]  a1 = '0, a2 = '0, a3 = '0;
  logic         fmsdu = 1'b0, fmpdu = 1'b0, lmpdu = 1'b0, fcse = 1'b0;
  logic [191:0] bssids;
  logic [47:0]  sta = 48'h00AA_BBCC_DD00;
  logic         out_valid, out_ready = 1'b1;
  logic [31:0]  st;
  logic [11:0]  sn;
  logic [3:0]   tid;
  logic         rty, prt, tds, fds;

  int checks = 0;
  int errors = 0;

  wlan_hdr_classifier uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .hdr_fc(fc), .hdr_duration(dur), .hdr_addr1(a1), .hdr_addr2(a2),
    .hdr_addr3(a3), .hdr_seq_ctl(seqc), .hdr_qos_ctl(qos),
    .first_msdu(fmsdu), .first_mpdu(fmpdu), .last_mpdu(lmpdu),
    .fcs_err(fcse), .bssid_tbl(bssids), .sta_addr(sta),
    .out_valid(out_valid), .out_ready(out_ready), .out_status(st),
    .out_seq_num(sn), .out_tid(tid), .out_retry(rty),
    .out_protected(prt), .out_to_ds(tds), .out_from_ds(fds)
  );

  function automatic logic [47:0] bss(input int k);
    return 48'h0012_3456_7800 + 48'(k);
  endfunction

  // address codes: 0 station, 1 broadcast, 2 other unicast, 3 unknown BSS, 4..7 BSSID 0..3
  function automatic logic [47:0] addr_of(input logic [2:0] c);
    case (c)
      3'd0:    return 48'h00AA_BBCC_DD00;
      3'd1:    return 48'hFFFF_FFFF_FFFF;
      3'd2:    return 48'h0000_0000_0A00;
      3'd3:    return 48'h0000_0000_0B00;
      default: return bss(int'(c) - 4);
    endcase
  endfunction

  typedef struct packed {
    logic [15:0] fc;
    logic [15:0] seqc;
    logic [15:0] qos;
    logic [2:0]  c1;
    logic [2:0]  c2;
    logic [2:0]  c3;
    logic        fmsdu;
    logic        fmpdu;
    logic        lmpdu;
    logic        fcs;
    logic [31:0] st;
    logic [3:0]  tid;
    logic [11:0] seq;
    logic [3:0]  fl;   // {retry, protected, to_ds, from_ds}
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{16'h0080, 16'h1230, 16'h0000, 3'd1, 3'd2, 3'd5, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_0107, 4'd0, 12'h123, 4'b0000},
    '{16'h3188, 16'h0452, 16'h0015, 3'd0, 3'd2, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0200_2C20, 4'd5, 12'h045, 4'b0010},
    '{16'h80C8, 16'hFFF0, 16'h0007, 3'd2, 3'd3, 3'd7, 1'b1, 1'b0, 1'b1, 1'b1, 32'h4000_4082, 4'd7, 12'hFFF, 4'b0000},
    '{16'h0448, 16'h0010, 16'h00FF, 3'd1, 3'd2, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_2084, 4'd0, 12'h001, 4'b0000},
    '{16'h0448, 16'h0010, 16'h00FF, 3'd1, 3'd2, 3'd4, 1'b0, 1'b1, 1'b0, 1'b1, 32'h4000_0001, 4'd0, 12'h000, 4'b0000},
    '{16'h48B4, 16'h5670, 16'h0000, 3'd1, 3'd3, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_0200, 4'd0, 12'h567, 4'b1100},
    '{16'h0208, 16'h0003, 16'h0010, 3'd1, 3'd6, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_2004, 4'd0, 12'h000, 4'b0001},
    '{16'h0308, 16'h0000, 16'h0000, 3'd1, 3'd4, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 4'd0, 12'h000, 4'b0011}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load(input vec_t v);
    fc = v.fc; seqc = v.seqc; qos = v.qos;
    a1 = addr_of(v.c1); a2 = addr_of(v.c2); a3 = addr_of(v.c3);
    fmsdu = v.fmsdu; fmpdu = v.fmpdu; lmpdu = v.lmpdu; fcse = v.fcs;
    dur = 16'h1234;
  endtask

  task automatic send(input vec_t v);
    @(negedge clk);
    load(v);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < 4; k++) bssids[k*48 +: 48] = bss(k);
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    vec_t va, vb, vg;
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset in_ready", {31'd0, in_ready}, 32'd1);
    check("R12 reset status", st, 32'd0);
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12
    for (int i = 0; i < 8; i++) begin
      send(VECS[i]);
      check($sformatf("R1 vec%0d valid", i), {31'd0, out_valid}, 32'd1);
      check($sformatf("R2 R3 R4 R5 R6 R7 R8 R9 R10 R12 vec%0d status", i), st, VECS[i].st);
      check($sformatf("R8 vec%0d tid", i), {28'd0, tid}, {28'd0, VECS[i].tid});
      check($sformatf("R11 vec%0d seq", i), {20'd0, sn}, {20'd0, VECS[i].seq});
      check($sformatf("R5 vec%0d fc bits", i), {28'd0, rty, prt, tds, fds}, {28'd0, VECS[i].fl});
    end

    // R9: group bit alone (not broadcast) with a BSSID hit
    vg = VECS[7];
    vg.fc = 16'h0008; vg.c2 = 3'd2; vg.c3 = 3'd7; vg.fl = 4'b0000;
    send(vg);
    a1 = 48'h0000_0000_0001;
    @(negedge clk);
    fc = 16'h0008; a3 = bss(3); fmsdu = 1'b1; fmpdu = 1'b0; lmpdu = 1'b0; fcse = 1'b0;
    seqc = '0; qos = '0;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 odd unicast-group address with BSSID hit", st, 32'h0000_0004);

    // R1: back-pressure
    va = VECS[1];
    vb = VECS[2];
    @(negedge clk);
    out_ready = 1'b0;
    send(va);
    check("R1 stall valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    load(vb);
    in_valid = 1'b1;
    check("R1 stall in_ready low", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    @(negedge clk);
    check("R1 stall holds status", st, va.st);
    check("R1 stall holds tid", {28'd0, tid}, {28'd0, va.tid});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 drain accepts waiting beat", st, vb.st);
    check("R1 drain valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    check("R1 empties after drain", {31'd0, out_valid}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule